// File: doc/BRIEF.md
# Framed Four-Lane Double-Edge Sample Serializer

This block takes one multi-channel sample word per sample period and shifts every channel out on its own serial lane, most significant bit first. It runs from a single clock at the serial bit rate. Next to the data lanes it drives a data clock that changes level once per bit period, so a receiver captures a new bit on each of its edges. It also drives a frame clock at the sample rate that is high during the first half of each byte and marks where each byte starts. With the defaults of four lanes and eight-bit samples, a 65 MS/s sample rate gives 520 Mb/s on each lane and a 260 MHz data clock.

An input flag reports whether the upstream clock generator has lost lock. The flag is high when lock is lost and low when lock is held. While it is high, every output stays where it was and any partly sent byte is abandoned. When lock returns, the data clock starts again and a complete new byte goes out, starting with its frame marker. A power-down input forces every output to a fixed low idle level. A sample word is moved into the lane shifters only at a byte boundary. Between boundaries, the newest accepted word waits in a holding register.

Top module: `ddr_lane_serializer`

## Requirements
- R1: During reset and after it, for as long as the lock-lost flag stays high, every lane, the data clock and the frame clock read 0.
- R2: Lane i carries bits [8i+7:8i] of the sample word. The eight bits go out in eight consecutive bit periods, bit 7 of the field first and bit 0 last. Bytes follow one another with no gap.
- R3: The frame clock is 1 during the first four bit periods of each byte and 0 during the last four. Unless power-down forces it low, it never falls until it has been high for at least four sampled periods.
- R4: While the block is locked and powered, the data clock changes level on every bit-clock edge.
- R5: A sample accepted in the middle of a byte does not change that byte. A sample presented in the cycle before a boundary is used for the byte that starts at that boundary. When no new sample arrives, the newest accepted word is sent again.
- R6: While the lock-lost flag is high, the lanes, the data clock and the frame clock keep their values.
- R7: When lock returns after being lost in the middle of a byte, the rest of that byte is never sent. The next bit sent is the MSB of a new byte, with the frame clock high.
- R8: A sample presented while the lock-lost flag is high is dropped. The first byte after lock returns carries the newest word accepted before lock was lost.
- R9: While power-down is high, all lanes, the data clock and the frame clock are driven to 0 and samples are dropped. Once power-down is released with lock held, a fresh framed byte starts, built from the newest word accepted before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_down | input | 1 | High forces all outputs to idle 0 and stops the stream |
| clkgen_unlock | input | 1 | High when the clock generator has lost lock, low when it is locked |
| smp_valid | input | 1 | One-cycle strobe that qualifies smp_data |
| smp_data | input | LANES*SAMPLE_W | Sample word, lane i at bits [SAMPLE_W*i +: SAMPLE_W] |
| lane_out | output | LANES | One serial data bit per lane |
| dclk_out | output | 1 | Data clock that changes level every bit period |
| fclk_out | output | 1 | Frame clock, high for the first half of each byte |

## Verification
The assertions check four properties on every cycle. The outputs stay frozen while lock is lost, and they are forced to idle while powered down. The data clock changes level on every locked, powered edge. Once the frame clock rises, it stays high for at least four periods. The bit order on each lane, the choice of which sample word fills which byte, and the dropping of samples while unlocked or powered down cannot be seen from one cycle. Only the bench's scenarios show them, by comparing each bit period against the word that should be on the wire.

// File: rtl/ser_pkg.sv
package ser_pkg;

  // Link condition of the serializer
  typedef enum logic [1:0] {
    LINK_OFF    = 2'd0,   // reset or powered down, outputs idle
    LINK_STREAM = 2'd1,   // bytes are being sent
    LINK_FROZEN = 2'd2    // lock lost, outputs held
  } link_state_e;

  // Per-cycle commands from the frame timer to the lane shifters
  typedef struct packed {
    logic clear;  // force idle
    logic load;   // begin a new byte
    logic shift;  // advance one bit
  } lane_ctrl_t;

endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ser_sample_hold.sv
module ser_sample_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              pwr_down,
  input  logic              clkgen_unlock,
  output logic [WORD_W-1:0] load_word
);

  logic              accept;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] hold_d;

  // samples offered while unlocked or powered down are discarded
  always_comb begin
    accept = smp_valid && !pwr_down && !clkgen_unlock;
    hold_d = accept ? smp_data : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= hold_d;
  end

  // bypass so a word offered right at the boundary goes out at once
  assign load_word = hold_d;

endmodule

// File: rtl/ser_frame_timer.sv
module ser_frame_timer
  import ser_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       clkgen_unlock,
  output lane_ctrl_t ctrl,
  output logic       dclk_out,
  output logic       fclk_out
);

  localparam int CW   = $clog2(SAMPLE_W);
  localparam int LAST = SAMPLE_W - 1;
  localparam int HALF = SAMPLE_W / 2;

  link_state_e     st_q, st_d;
  logic [CW-1:0]   idx_q, idx_d;
  logic [CW:0]     idx_inc;
  logic            dclk_q, dclk_d;
  logic            fclk_q, fclk_d;
  logic            active, start, advance;

  always_comb begin
    active  = !pwr_down && !clkgen_unlock;
    start   = active && ((st_q != LINK_STREAM) || (idx_q == CW'(LAST)));
    advance = active && !start;
    idx_inc = {1'b0, idx_q} + (CW+1)'(1);

    st_d   = st_q;
    idx_d  = idx_q;
    dclk_d = dclk_q;
    fclk_d = fclk_q;

    if (pwr_down) begin
      st_d   = LINK_OFF;
      idx_d  = '0;
      dclk_d = 1'b0;
      fclk_d = 1'b0;
    end else if (clkgen_unlock) begin
      st_d = (st_q == LINK_OFF) ? LINK_OFF : LINK_FROZEN;
    end else if (start) begin
      st_d   = LINK_STREAM;
      idx_d  = '0;
      dclk_d = ~dclk_q;
      fclk_d = 1'b1;
    end else if (advance) begin
      idx_d  = idx_inc[CW-1:0];
      dclk_d = ~dclk_q;
      fclk_d = (idx_inc < (CW+1)'(HALF));
    end

    ctrl.clear = pwr_down;
    ctrl.load  = start;
    ctrl.shift = advance;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LINK_OFF;
      idx_q  <= '0;
      dclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      dclk_q <= dclk_d;
      fclk_q <= fclk_d;
    end
  end

  assign dclk_out = dclk_q;
  assign fclk_out = fclk_q;

endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift
  import ser_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lane_ctrl_t          ctrl,
  input  logic [SAMPLE_W-1:0] word,
  output logic                bit_out
);

  logic [SAMPLE_W-1:0] sh_q, sh_d;
  logic                bit_q, bit_d;
  logic                en;

  always_comb begin
    en    = ctrl.clear || ctrl.load || ctrl.shift;
    sh_d  = sh_q;
    bit_d = bit_q;
    if (ctrl.clear) begin
      sh_d  = '0;
      bit_d = 1'b0;
    end else if (ctrl.load) begin
      bit_d = word[SAMPLE_W-1];
      sh_d  = {word[SAMPLE_W-2:0], 1'b0};
    end else if (ctrl.shift) begin
      bit_d = sh_q[SAMPLE_W-1];
      sh_d  = {sh_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else if (en) begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign bit_out = bit_q;

endmodule

// File: rtl/ddr_lane_serializer.sv
module ddr_lane_serializer
  import ser_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwr_down,
  input  logic                      clkgen_unlock,
  input  logic                      smp_valid,
  input  logic [LANES*SAMPLE_W-1:0] smp_data,
  output logic [LANES-1:0]          lane_out,
  output logic                      dclk_out,
  output logic                      fclk_out
);

  localparam int WORD_W = LANES * SAMPLE_W;

  logic              rst_n_sync;
  logic [WORD_W-1:0] load_word;
  lane_ctrl_t        ctrl;

  ser_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ser_sample_hold #(.WORD_W(WORD_W)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .smp_valid     (smp_valid),
    .smp_data      (smp_data),
    .pwr_down      (pwr_down),
    .clkgen_unlock (clkgen_unlock),
    .load_word     (load_word)
  );

  ser_frame_timer #(.SAMPLE_W(SAMPLE_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .pwr_down      (pwr_down),
    .clkgen_unlock (clkgen_unlock),
    .ctrl          (ctrl),
    .dclk_out      (dclk_out),
    .fclk_out      (fclk_out)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser_lane_shift #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .ctrl    (ctrl),
      .word    (load_word[g*SAMPLE_W +: SAMPLE_W]),
      .bit_out (lane_out[g])
    );
  end

endmodule

// File: rtl/ser_chk.sv
module ser_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             clkgen_unlock,
  input logic [LANES-1:0] lane_out,
  input logic             dclk_out,
  input logic             fclk_out
);

  // R6
  freeze_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkgen_unlock && !pwr_down) |=> ($stable(lane_out) && $stable(dclk_out) && $stable(fclk_out)));

  // R9
  idle_in_pwr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (lane_out == '0 && !dclk_out && !fclk_out));

  // R4
  dclk_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !clkgen_unlock) |=> (dclk_out != $past(dclk_out)));

  // R3
  frame_high_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fclk_out) && !$past(pwr_down)) |-> ($past(fclk_out, 2) && $past(fclk_out, 3) && $past(fclk_out, 4)));

endmodule

bind ddr_lane_serializer ser_chk #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .pwr_down      (pwr_down),
  .clkgen_unlock (clkgen_unlock),
  .lane_out      (lane_out),
  .dclk_out      (dclk_out),
  .fclk_out      (fclk_out)
);

// File: tb/ddr_lane_serializer_tb.sv
module ddr_lane_serializer_tb;

  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'hA53C0FF0, 32'h00FF00FF, 32'h817E4224,
    32'h12345678, 32'hFFFFFFFF, 32'h00000000
  };

  logic        clk = 1'b0;
  logic        rst_n, pwr_down, clkgen_unlock, smp_valid;
  logic [31:0] smp_data;
  logic [3:0]  lane_out;
  logic        dclk_out, fclk_out;
  logic        prev_dclk;
  logic [5:0]  snap;
  int          checks = 0;
  int          fails  = 0;

  always #5 clk = ~clk;

  ddr_lane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .clkgen_unlock(clkgen_unlock),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .lane_out(lane_out), .dclk_out(dclk_out), .fclk_out(fclk_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lane_bits(input logic [31:0] s, input int k);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = s[8*i + 7 - k];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one bit period of a byte: lanes (R2), frame (R3), data clock (R4)
  task automatic check_bit(input logic [31:0] s, input int k, input string req);
    logic [3:0] e;
    e = lane_bits(s, k);
    chk(lane_out == e, req, {28'd0, lane_out}, {28'd0, e});
    chk(fclk_out == (k < 4), "R3 frame", {31'd0, fclk_out}, {31'd0, (k < 4)});
    chk(dclk_out != prev_dclk, "R4 dclk", {31'd0, dclk_out}, {31'd0, ~prev_dclk});
    prev_dclk = dclk_out;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] a_w, b_w, d_w;
    a_w = 32'hC35A96E1;
    b_w = 32'h1E2D3C4B;
    d_w = 32'h69960F3C;
    rst_n = 1'b0; pwr_down = 1'b0; clkgen_unlock = 1'b1;
    smp_valid = 1'b0; smp_data = '0;
    repeat (3) tick();
    chk({lane_out, dclk_out, fclk_out} == 6'd0, "R1 in reset", {26'd0, lane_out, dclk_out, fclk_out}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk({lane_out, dclk_out, fclk_out} == 6'd0, "R1 after reset", {26'd0, lane_out, dclk_out, fclk_out}, 0);
    prev_dclk = 1'b0;

    // table walk: each byte gets a mid-byte decoy that must not disturb it (R2, R5)
    for (int v = 0; v < NV; v++) begin
      smp_data = VEC[v]; smp_valid = 1'b1; clkgen_unlock = 1'b0;
      for (int k = 0; k < 8; k++) begin
        tick();
        check_bit(VEC[v], k, "R2 lane bits");
        if (k == 0) smp_valid = 1'b0;
        if (k == 3) begin smp_data = ~VEC[v]; smp_valid = 1'b1; end
        if (k == 4) smp_valid = 1'b0;
      end
    end

    // no new sample: newest accepted word (last decoy) repeats (R5)
    for (int k = 0; k < 8; k++) begin
      tick();
      check_bit(~VEC[NV-1], k, "R5 repeat newest");
    end

    // lock lost after three bits, sample offered while unlocked
    smp_data = a_w; smp_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check_bit(a_w, k, "R2 lane bits");
      smp_valid = 1'b0;
    end
    clkgen_unlock = 1'b1; smp_data = b_w; smp_valid = 1'b1;
    snap = {lane_out, dclk_out, fclk_out};
    for (int n = 0; n < 3; n++) begin
      tick();
      chk({lane_out, dclk_out, fclk_out} == snap, "R6 frozen", {26'd0, lane_out, dclk_out, fclk_out}, {26'd0, snap});
    end
    clkgen_unlock = 1'b0; smp_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      check_bit(a_w, k, "R7 R8 restart byte");
    end

    // power-down in the middle of a byte
    smp_data = d_w; smp_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      check_bit(d_w, k, "R2 lane bits");
      smp_valid = 1'b0;
    end
    pwr_down = 1'b1; smp_data = b_w; smp_valid = 1'b1;
    for (int n = 0; n < 2; n++) begin
      tick();
      chk({lane_out, dclk_out, fclk_out} == 6'd0, "R9 idle", {26'd0, lane_out, dclk_out, fclk_out}, 0);
    end
    pwr_down = 1'b0; smp_valid = 1'b0;
    prev_dclk = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      check_bit(d_w, k, "R9 resume byte");
    end

    finish_run();
  end

endmodule